// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block holds an 8-bit up-counter that software can read and overwrite, together with one 8-bit programmable divider. The divider serves only one client at a time: the timer or the watchdog. A 6-bit control value picks the count source, which is either the instruction-cycle enable or an already synchronized external pin. The same value picks the active pin edge, the divider's client and the divide ratio.

Every count event passes through a two-stage pipeline that advances on instruction cycles. This gives a fixed latency from event to increment. The pipeline is flushed when the timer is written, so a written value holds for two instruction cycles.

When the watchdog owns the divider, the block divides the watchdog's raw time-base pulses and hands the result to the watchdog. The watchdog-clear or sleep event restarts the divider in that case. When the timer owns the divider, the watchdog receives its raw time base unchanged.

Top module: `evt_timer_top`

## Requirements
- R1: After reset the timer reads 00h and the control value is 3Fh. The control fields are: bit 5 source (1 = external pin, 0 = instruction-cycle enable), bit 4 edge (1 = falling, 0 = rising), bit 3 divider client (0 = timer, 1 = watchdog), bits 2:0 ratio code. A control load takes effect in the next cycle.
- R2: With the internal source and the divider given to the watchdog, the timer gains one for every instruction-cycle enable.
- R3: With the external source, only the selected pin edge is counted; the opposite edge has no effect.
- R4: An event is captured at the first instruction-cycle edge at or after it. The timer increments at the second instruction-cycle edge after that capture; otherwise the timer holds.
- R5: The timer wraps from FFh to 00h.
- R6: A timer write loads the data at the next edge, overrides any increment and discards events in flight. The value stays fixed through the next two instruction-cycle edges and can first change at the third.
- R7: With the divider on the timer, ratio code c passes one increment per 2^(c+1) qualified events.
- R8: A timer write clears the divider when it serves the timer, and leaves the control value unchanged.
- R9: With the divider on the watchdog, wdt_tick pulses in the same cycle as every 2^(c+1)-th wdt_base pulse counted since the divider was last cleared.
- R10: With the divider on the watchdog, wdt_clr clears it and a timer write does not. With the divider on the timer, wdt_clr has no effect on it.
- R11: With the divider on the timer, wdt_tick follows wdt_base in the same cycle.
- R12: Loading 07h selects the internal source, gives the divider to the timer and divides by 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock instruction-cycle enable |
| ext_pin | input | 1 | External count input, already synchronized |
| ctl_ld | input | 1 | Load strobe for the control value |
| ctl_wdata | input | 6 | Control value to load |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wdt_base | input | 1 | Raw watchdog time-base pulse |
| wdt_clr | input | 1 | Watchdog-clear or sleep event |
| tmr_value | output | 8 | Current timer value |
| wdt_tick | output | 1 | Time-base pulse delivered to the watchdog |

## Verification
The assertions assume that ext_pin is already in the clock domain and that wdt_base, wdt_clr and cyc_en are single-clock qualifiers. They also assume that a timer write, a divider clear and an increment are judged in the cycle their strobe is seen. The stimulus changes every input only just after the falling clock edge. It holds each pin level for at least three clocks, so every edge is seen exactly once. Control loads are never issued in the same cycle as a timer write.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int unsigned RATIO_W = 3;

  // Control layout, MSB first: source, edge, divider client, ratio code
  typedef struct packed {
    logic               src_ext;
    logic               edge_fall;
    logic               to_wdt;
    logic [RATIO_W-1:0] ratio;
  } tmr_ctl_t;

  localparam int unsigned CTL_W = $bits(tmr_ctl_t);

endpackage

// File: rtl/evt_event_qual.sv
module evt_event_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic pin,
  input  logic src_ext,
  input  logic edge_fall,
  output logic evt
);

  logic pin_q;
  logic pin_rise;
  logic pin_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign pin_rise = pin & ~pin_q;
  assign pin_fall = ~pin & pin_q;

  always_comb begin
    if (src_ext) evt = edge_fall ? pin_fall : pin_rise;
    else         evt = cyc_en;
  end

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic               clr,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick_out,
  output logic [PRE_W-1:0]   cnt_o
);

  // Terminal count for ratio code c is 2^(c+1)-1
  function automatic logic [PRE_W-1:0] last_count(input logic [RATIO_W-1:0] code);
    return (((PRE_W'(1) << code) - PRE_W'(1)) << 1) | PRE_W'(1);
  endfunction

  logic [PRE_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q >= last_count(ratio));
  assign tick_out = tick_in & at_last & ~clr;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tick_in) cnt_q <= at_last ? '0 : cnt_q + PRE_W'(1);
  end

endmodule

// File: rtl/evt_sync_counter.sv
module evt_sync_counter #(
  parameter int unsigned TMR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             evt_in,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] value,
  output logic             inc_evt
);

  logic                   pend_q;
  logic                   catch_evt;
  logic [SYNC_STAGES-1:0] stg_q;

  assign catch_evt = pend_q | evt_in;
  assign inc_evt   = cyc_en & stg_q[SYNC_STAGES-1] & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stg_q  <= '0;
      value  <= '0;
    end else if (load) begin
      pend_q <= 1'b0;
      stg_q  <= '0;
      value  <= load_val;
    end else begin
      if (cyc_en) begin
        stg_q  <= (stg_q << 1) | SYNC_STAGES'(catch_evt);
        pend_q <= 1'b0;
      end else begin
        pend_q <= catch_evt;
      end
      if (inc_evt) value <= value + TMR_W'(1);
    end
  end

endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int unsigned TMR_W       = 8,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             ext_pin,
  input  logic             ctl_ld,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             wdt_base,
  input  logic             wdt_clr,
  output logic [TMR_W-1:0] tmr_value,
  output logic             wdt_tick
);

  tmr_ctl_t         ctl_q;
  logic             qual_evt;
  logic             pre_on_tmr;
  logic             pre_in;
  logic             pre_clr;
  logic             pre_out;
  logic             cnt_evt;
  logic             inc_evt;
  logic [PRE_W-1:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '1;
    else if (ctl_ld) ctl_q <= tmr_ctl_t'(ctl_wdata);
  end

  evt_event_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .pin       (ext_pin),
    .src_ext   (ctl_q.src_ext),
    .edge_fall (ctl_q.edge_fall),
    .evt       (qual_evt)
  );

  // Divider routing: one client at a time
  assign pre_on_tmr = ~ctl_q.to_wdt;
  assign pre_in     = pre_on_tmr ? qual_evt : wdt_base;
  assign pre_clr    = pre_on_tmr ? tmr_wr   : wdt_clr;
  assign cnt_evt    = pre_on_tmr ? pre_out  : qual_evt;
  assign wdt_tick   = pre_on_tmr ? wdt_base : pre_out;

  evt_prescaler #(
    .PRE_W   (PRE_W),
    .RATIO_W (RATIO_W)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (pre_in),
    .clr      (pre_clr),
    .ratio    (ctl_q.ratio),
    .tick_out (pre_out),
    .cnt_o    (pre_cnt)
  );

  evt_sync_counter #(
    .TMR_W       (TMR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .evt_in   (cnt_evt),
    .load     (tmr_wr),
    .load_val (tmr_wdata),
    .value    (tmr_value),
    .inc_evt  (inc_evt)
  );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int unsigned TMR_W = 8,
  parameter int unsigned PRE_W = 8,
  parameter int unsigned HOLD  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             tmr_wr,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic             wdt_base,
  input logic             wdt_clr,
  input logic [TMR_W-1:0] tmr_value,
  input logic             wdt_tick,
  input logic             pre_on_tmr,
  input logic             inc_evt,
  input logic [PRE_W-1:0] pre_cnt
);

  // Instruction-cycle edges since the last write or reset, saturating at 3
  logic [1:0] since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_wr <= 2'd0;
    else if (tmr_wr)                     since_wr <= 2'd0;
    else if (cyc_en && since_wr != 2'd3) since_wr <= since_wr + 2'd1;
  end

  assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> tmr_value == $past(tmr_wdata));

  assert_hold_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |-> since_wr >= 2'(HOLD));

  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> tmr_value == $past(tmr_value) + TMR_W'(1));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_evt && !tmr_wr) |=> $stable(tmr_value));

  assert_pre_clear_tmr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_on_tmr && tmr_wr) |=> pre_cnt == '0);

  assert_pre_clear_wdt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_on_tmr && wdt_clr) |=> pre_cnt == '0);

  assert_tick_needs_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick |-> wdt_base);

endmodule

bind evt_timer_top evt_timer_chk #(
  .TMR_W (TMR_W),
  .PRE_W (PRE_W),
  .HOLD  (SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_en     (cyc_en),
  .tmr_wr     (tmr_wr),
  .tmr_wdata  (tmr_wdata),
  .wdt_base   (wdt_base),
  .wdt_clr    (wdt_clr),
  .tmr_value  (tmr_value),
  .wdt_tick   (wdt_tick),
  .pre_on_tmr (pre_on_tmr),
  .inc_evt    (inc_evt),
  .pre_cnt    (pre_cnt)
);

// File: tb/test_evt_timer_top.sv
module test_evt_timer_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       ctl_ld = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic       tmr_wr = 1'b0;
  logic [7:0] tmr_wdata = '0;
  logic       wdt_base = 1'b0;
  logic       wdt_clr = 1'b0;
  wire  [7:0] tmr_value;
  wire        wdt_tick;

  always #5 clk = ~clk;

  evt_timer_top i_evt_timer_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .ext_pin   (ext_pin),
    .ctl_ld    (ctl_ld),
    .ctl_wdata (ctl_wdata),
    .tmr_wr    (tmr_wr),
    .tmr_wdata (tmr_wdata),
    .wdt_base  (wdt_base),
    .wdt_clr   (wdt_clr),
    .tmr_value (tmr_value),
    .wdt_tick  (wdt_tick)
  );

  typedef struct {
    bit         is_tick;
    logic [7:0] exp;
    string      req;
  } exp_item_t;

  exp_item_t exp_q[$];
  event      sample_ev;
  int        n_run  = 0;
  int        n_fail = 0;
  bit        done   = 1'b0;

  // Monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_item_t it;
        logic [7:0] act;
        it  = exp_q.pop_front();
        act = it.is_tick ? {7'd0, wdt_tick} : tmr_value;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: %s actual=%02h expected=%02h", it.req,
                   it.is_tick ? "wdt_tick" : "tmr_value", act, it.exp);
        end
      end
    end
  end

  task automatic push_exp(bit is_tick, logic [7:0] v, string req);
    exp_item_t it;
    it.is_tick = is_tick;
    it.exp     = v;
    it.req     = req;
    exp_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic expect_tmr(logic [7:0] v, string req);
    push_exp(1'b0, v, req);
  endtask

  task automatic expect_tick(bit v, string req);
    push_exp(1'b1, {7'd0, v}, req);
  endtask

  task automatic load_ctl(logic [5:0] v);
    @(negedge clk); ctl_ld = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_ld = 1'b0;
  endtask

  task automatic write_tmr(logic [7:0] d);
    @(negedge clk); tmr_wr = 1'b1; tmr_wdata = d;
    @(negedge clk); tmr_wr = 1'b0;
    #1;
  endtask

  // After a write with cyc_en always high: value after edge k = d + floor((k-2)/div)
  task automatic run_check(logic [7:0] d, int div, int kmax, string req);
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk); #1;
      expect_tmr(8'(d + ((k >= 2) ? (k - 2) / div : 0)), req);
    end
  endtask

  task automatic base_pulse(bit exp_tick, string req);
    @(negedge clk); wdt_base = 1'b1; #1;
    expect_tick(exp_tick, req);
    @(negedge clk); wdt_base = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      #1;
      if (exp_q.size() > 0) begin -> sample_ev; #1; end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R-all: watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_tmr(8'h00, "R1 reset value");
    cyc_en = 1'b1;

    // R1: reset control 3Fh -> watchdog owns divider at 1:256
    for (int i = 1; i <= 256; i++) base_pulse(i == 256, "R1 reset divider");
    expect_tmr(8'h00, "R1 external source, no pin edges");

    // R2: internal source, undivided
    load_ctl(6'h0F);
    write_tmr(8'h10);
    expect_tmr(8'h10, "R6 load");
    run_check(8'h10, 1, 8, "R2");

    // R5: wrap
    write_tmr(8'hFE);
    run_check(8'hFE, 1, 6, "R5");

    // R6: hold with sparse instruction cycles
    cyc_en = 1'b0;
    write_tmr(8'h30);
    for (int c = 1; c <= 4; c++) begin
      logic [7:0] before_v;
      before_v = (c <= 3) ? 8'h30 : 8'h31;
      repeat (3) @(negedge clk);
      #1 expect_tmr(before_v, "R6 no cyc_en");
      @(negedge clk); cyc_en = 1'b1;
      @(negedge clk); cyc_en = 1'b0;
      #1 expect_tmr((c <= 2) ? 8'h30 : 8'(8'h30 + c - 2), "R6 third cycle");
    end
    cyc_en = 1'b1;

    // R7: divider on timer
    load_ctl(6'h00);
    write_tmr(8'h00);
    run_check(8'h00, 2, 12, "R7 div2");
    load_ctl(6'h02);
    write_tmr(8'h80);
    run_check(8'h80, 8, 20, "R7 div8");

    // R8: second write restarts the divider
    write_tmr(8'h20);
    repeat (5) @(negedge clk);
    write_tmr(8'h20);
    run_check(8'h20, 8, 12, "R8");

    // R10: wdt_clr ignored while divider serves timer
    load_ctl(6'h00);
    wdt_clr = 1'b1;
    write_tmr(8'h50);
    run_check(8'h50, 2, 10, "R10 timer-owned");
    wdt_clr = 1'b0;

    // R12: 07h -> internal, timer, 1:256
    load_ctl(6'h07);
    write_tmr(8'h00);
    run_check(8'h00, 256, 260, "R12");

    // R3/R4: external rising
    load_ctl(6'h28);
    write_tmr(8'h40);
    repeat (3) @(negedge clk);
    @(negedge clk); ext_pin = 1'b1; #1;
    expect_tmr(8'h40, "R4 pre-edge");
    @(negedge clk); #1 expect_tmr(8'h40, "R4 captured");
    @(negedge clk); #1 expect_tmr(8'h40, "R4 stage two");
    @(negedge clk); #1 expect_tmr(8'h41, "R4 increment");
    @(negedge clk); ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    #1 expect_tmr(8'h41, "R3 fall ignored in rising mode");
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); ext_pin = 1'b1;
      repeat (3) @(negedge clk); ext_pin = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    #1 expect_tmr(8'h46, "R3 rising pulses");

    // R3: external falling
    load_ctl(6'h38);
    @(negedge clk); ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    #1 expect_tmr(8'h46, "R3 rise ignored in falling mode");
    @(negedge clk); ext_pin = 1'b0;
    repeat (3) @(negedge clk);
    #1 expect_tmr(8'h47, "R3 falling counted");

    // R9: divider on watchdog, 1:8
    load_ctl(6'h0A);
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
    for (int i = 1; i <= 16; i++) base_pulse((i % 8) == 0, "R9");

    // R10: wdt_clr restarts it
    for (int i = 1; i <= 5; i++) base_pulse(1'b0, "R10 before clear");
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
    for (int i = 1; i <= 8; i++) base_pulse(i == 8, "R10 after clear");

    // R10: timer write does not touch a watchdog-owned divider
    for (int i = 1; i <= 5; i++) base_pulse(1'b0, "R10 before write");
    write_tmr(8'h99);
    for (int i = 1; i <= 3; i++) base_pulse(i == 3, "R10 write ignored");

    // R11: timer-owned divider, raw base passes through
    load_ctl(6'h00);
    for (int i = 1; i <= 3; i++) begin
      base_pulse(1'b1, "R11 high");
      #1 expect_tick(1'b0, "R11 low");
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule